// File: doc/BRIEF.md
# SPDIF Subframe Word Packer

This block sits between a biphase-mark receiver that has already decoded SPDIF subframes and a receive buffer that stores 32-bit words. Each subframe arrives on a single-cycle strobe. It carries a 24-bit audio field together with its validity, user, channel-status and parity bits. The block turns those subframes into 32-bit words and presents them on a valid/ready output. PCM and compressed streams are packed by the same rules.

Two packing formats are selected by a mode input. In narrow mode the block keeps the upper 16 bits of each audio field and joins two consecutive samples into one word. In wide mode each subframe becomes one word: the sample sits in the low bits and the bits above it are zero. In wide mode only, a report input places the four per-subframe status bits directly above the sample. The output has a single holding register. When a word completes while that register is still occupied, the new word is lost and a sticky overflow flag is raised. The flag stays set until the clear input is pulsed.

Top module: `spdif_word_packer`

## Requirements
- R1: After reset `out_valid` and `ovf_flag` are 0 and no narrow half is pending. A half that is pending when reset is asserted is discarded.
- R2: In narrow mode (`cfg_wide`=0) only bits [23:8] of each audio field are kept. The lower 8 bits never reach the output.
- R3: In narrow mode the first sample of a pair lands in `out_data[15:0]` and the second in `out_data[31:16]`. A word is emitted only when the second sample arrives.
- R4: In wide mode (`cfg_wide`=1) each subframe produces one word with the sample in `out_data[23:0]` and `out_data[31:24]` zero while `cfg_report`=0. For example, an all-ones sample gives 0x00FFFFFF.
- R5: In wide mode with `cfg_report`=1, `out_data[27:24]` carries {parity, channel-status, user, validity}, MSB to LSB, and `out_data[31:28]` stays zero.
- R6: In narrow mode `cfg_report` has no effect on the output words.
- R7: If `cfg_wide` is 1 while a narrow half is pending, that half is dropped. A wide subframe arriving in that cycle forms its own word, and later narrow packing starts with an empty word. Settings are applied per word, so no word mixes modes.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` stays unchanged.
- R9: If a word completes while `out_valid`=1 and `out_ready`=0, that word is dropped and `ovf_flag` is set. A word completing in a cycle where the held word is taken (`out_ready`=1) is accepted without overflow.
- R10: `ovf_flag` stays 1 until `ovf_clear` is asserted, and clears on the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 0 = narrow two-sample packing, 1 = wide one-sample packing |
| cfg_report | input | 1 | Carry status bits in wide mode |
| sf_valid | input | 1 | One-cycle strobe: a subframe is present |
| sf_audio | input | 24 | Audio field of the subframe |
| sf_v | input | 1 | Validity bit |
| sf_u | input | 1 | User bit |
| sf_c | input | 1 | Channel-status bit |
| sf_p | input | 1 | Parity bit |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Packed word |
| ovf_flag | output | 1 | Sticky: a completed word was dropped |
| ovf_clear | input | 1 | Clears `ovf_flag` |

## Verification
The bench uses the default parameters: a 24-bit audio field and a 32-bit word, so each narrow half is 16 bits and the status nibble sits at [27:24]. These values make every field position in the requirements visible at the ports. Audio patterns differ in their low byte and in their upper 16 bits, which exposes both truncation and half ordering. Back-pressure scenarios cover a word completing against a held word, and a word completing in the same cycle the held word is taken.

// File: rtl/spdif_word_packer.sv
module spdif_word_packer #(
  parameter int AUD_W = 24,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wide,
  input  logic             cfg_report,
  input  logic             sf_valid,
  input  logic [AUD_W-1:0] sf_audio,
  input  logic             sf_v,
  input  logic             sf_u,
  input  logic             sf_c,
  input  logic             sf_p,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             ovf_flag,
  input  logic             ovf_clear
);
  localparam int HALF_W = OUT_W / 2;

  logic              pend_q;
  logic [HALF_W-1:0] lo_q;
  logic [OUT_W-1:0]  wide_word;
  logic [OUT_W-1:0]  new_word;
  logic              complete, accept;

  always_comb begin
    wide_word = '0;
    wide_word[AUD_W-1:0] = sf_audio;
    if (cfg_report) wide_word[AUD_W+3:AUD_W] = {sf_p, sf_c, sf_u, sf_v};
  end

  assign new_word = cfg_wide ? wide_word : {sf_audio[AUD_W-1 -: HALF_W], lo_q};
  assign complete = sf_valid && (cfg_wide || pend_q);
  assign accept   = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lo_q   <= '0;
    end else if (cfg_wide) begin
      pend_q <= 1'b0;
    end else if (sf_valid) begin
      pend_q <= !pend_q;
      if (!pend_q) lo_q <= sf_audio[AUD_W-1 -: HALF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (complete && accept) begin
      out_valid <= 1'b1;
      out_data  <= new_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    ovf_flag <= 1'b0;
    else if (complete && !accept)  ovf_flag <= 1'b1;
    else if (ovf_clear)            ovf_flag <= 1'b0;
  end

  a_r4_wide_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_valid && cfg_wide && !cfg_report && accept) |=> (out_valid && out_data[OUT_W-1:AUD_W] == '0));
  a_r5_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_valid && cfg_wide && accept) |=> (out_data[OUT_W-1:AUD_W+4] == '0));
  a_r3_first_half_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_valid && !cfg_wide && !pend_q && !out_valid) |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r9_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && out_valid && !out_ready) |=> ovf_flag);
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clear) |=> ovf_flag);
  a_r7_wide_drops_half: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wide |=> !pend_q);
endmodule

// File: tb/sim_spdif_word_packer.sv
module sim_spdif_word_packer;
  logic        clk = 0, rst_n = 0;
  logic        cfg_wide = 0, cfg_report = 0, sf_valid = 0;
  logic [23:0] sf_audio = '0;
  logic        sf_v = 0, sf_u = 0, sf_c = 0, sf_p = 0;
  logic        out_valid, out_ready = 1, ovf_flag, ovf_clear = 0;
  logic [31:0] out_data;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  spdif_word_packer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_report(cfg_report),
    .sf_valid(sf_valid), .sf_audio(sf_audio), .sf_v(sf_v), .sf_u(sf_u),
    .sf_c(sf_c), .sf_p(sf_p), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .ovf_flag(ovf_flag), .ovf_clear(ovf_clear));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [23:0] a, logic [3:0] pcuv);
    sf_valid = 1; sf_audio = a; {sf_p, sf_c, sf_u, sf_v} = pcuv;
    @(negedge clk);
    sf_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; idle(2); rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 out_valid after reset", {31'b0, out_valid}, 0);
    chk("R1 ovf_flag after reset", {31'b0, ovf_flag}, 0);
  endtask

  task automatic t_narrow();
    cfg_wide = 0; cfg_report = 0;
    send(24'hABCDEF, 4'h0);
    chk("R3 no word after first half", {31'b0, out_valid}, 0);
    send(24'h123456, 4'h0);
    chk("R2 R3 narrow pair valid", {31'b0, out_valid}, 1);
    chk("R2 R3 narrow pair data", out_data, 32'h1234ABCD);
    send(24'hFFFF00, 4'h0);
    send(24'h0001FF, 4'h0);
    chk("R2 narrow truncation", out_data, 32'h0001FFFF);
    idle(1);
  endtask

  task automatic t_wide();
    cfg_wide = 1; cfg_report = 0;
    send(24'hFFFFFF, 4'hF);
    chk("R4 wide all ones", out_data, 32'h00FFFFFF);
    chk("R4 wide valid", {31'b0, out_valid}, 1);
    idle(1);
  endtask

  task automatic t_report();
    cfg_wide = 1; cfg_report = 1;
    send(24'h000001, 4'b0101);
    chk("R5 status C,V", out_data, 32'h05000001);
    send(24'h000000, 4'b1000);
    chk("R5 status P only", out_data, 32'h08000000);
    send(24'hFFFFFF, 4'hF);
    chk("R5 status all with full sample", out_data, 32'h0FFFFFFF);
    idle(1);
  endtask

  task automatic t_narrow_report();
    cfg_wide = 0; cfg_report = 1;
    send(24'h1111FF, 4'hF);
    send(24'h2222FF, 4'hF);
    chk("R6 report ignored in narrow", out_data, 32'h22221111);
    cfg_report = 0;
    idle(1);
  endtask

  task automatic t_switch();
    cfg_wide = 0;
    send(24'hAAAA00, 4'h0);
    cfg_wide = 1; idle(1); cfg_wide = 0;
    chk("R7 nothing emitted on drop", {31'b0, out_valid}, 0);
    send(24'h111100, 4'h0);
    send(24'h222200, 4'h0);
    chk("R7 fresh word after mode change", out_data, 32'h22221111);
    send(24'h333300, 4'h0);
    cfg_wide = 1;
    send(24'h000042, 4'h0);
    chk("R7 wide subframe forms own word", out_data, 32'h00000042);
    cfg_wide = 0;
    send(24'h444400, 4'h0);
    send(24'h555500, 4'h0);
    chk("R7 narrow restarts empty", out_data, 32'h55554444);
    idle(1);
  endtask

  task automatic t_reset_mid();
    cfg_wide = 0;
    send(24'h777700, 4'h0);
    do_reset();
    send(24'h111100, 4'h0);
    chk("R1 no word after reset half", {31'b0, out_valid}, 0);
    send(24'h222200, 4'h0);
    chk("R1 pending half dropped by reset", out_data, 32'h22221111);
    idle(1);
  endtask

  task automatic t_backpressure();
    cfg_wide = 1; cfg_report = 0; out_ready = 0;
    send(24'h000010, 4'h0);
    chk("R8 word presented", out_data, 32'h00000010);
    idle(2);
    chk("R8 held valid", {31'b0, out_valid}, 1);
    chk("R8 held data", out_data, 32'h00000010);
    send(24'h000020, 4'h0);
    chk("R9 held word kept", out_data, 32'h00000010);
    chk("R9 overflow set", {31'b0, ovf_flag}, 1);
    out_ready = 1; idle(1);
    chk("R8 word taken", {31'b0, out_valid}, 0);
    idle(2);
    chk("R10 flag sticky", {31'b0, ovf_flag}, 1);
    ovf_clear = 1; idle(1); ovf_clear = 0;
    chk("R10 flag cleared", {31'b0, ovf_flag}, 0);
    out_ready = 0;
    send(24'h000030, 4'h0);
    out_ready = 1;
    send(24'h000040, 4'h0);
    chk("R9 same-cycle take accepts", out_data, 32'h00000040);
    chk("R9 no overflow on take", {31'b0, ovf_flag}, 0);
    idle(1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_narrow();
    t_wide();
    t_report();
    t_narrow_report();
    t_switch();
    t_reset_mid();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule